// File: doc/BRIEF.md
# City-Block Nearest-Prototype Array

This block is a small single-instruction, multiple-data array of identical processing elements. Each element keeps one reference vector of 6-bit components in a local 64-word weight memory. It also has a 12-bit distance accumulator and a 6-bit address counter that points into that memory. A controller issues one instruction per cycle on a shared opcode bus, with a 12-bit data word and an element-enable mask. Every enabled element carries out the same instruction on its own state. The distance instruction adds the absolute difference between the broadcast component and the addressed weight to the accumulator, then advances the counter. A full city-block distance therefore takes one instruction per dimension.

The nearest prototype is found by a bit-serial search rather than a comparator tree. Each enabled element presents its inverted accumulator one bit per cycle, starting at the most significant bit, onto a wired-OR line. An element whose bit is 0 while the line reads 1 leaves the search. The line values, inverted again, make up the minimum distance. The lowest-indexed element that remains is reported as the winner.

Top module: `proto_match_array`

## Requirements
- R1: After reset, busy, done, read-valid and hit are 0, and read data, minimum distance and winner index are 0.
- R2: Opcode 4 (store weight) writes data bits 5:0 into the enabled elements' weight word at their counter, then increments the counter, which wraps modulo 64.
- R3: Opcode 1 (set counter) loads data bits 5:0 into the enabled elements' address counter.
- R4: Opcode 5 (accumulate) adds the absolute difference between data bits 5:0 and the addressed weight to the accumulator, modulo 4096, then increments the counter.
- R5: Opcode 2 (load accumulator) loads the 12-bit data word into the enabled accumulators. Opcode 3 (read) returns, one cycle later, the bitwise OR of the enabled elements' accumulators on the read data output, with read-valid high for that cycle.
- R6: An element whose mask bit is 0 is not changed by any opcode, and opcode 0 changes nothing.
- R7: Opcode 6 (search) raises busy for 13 cycles. Then done pulses for one cycle, and the minimum-distance output holds the smallest accumulator among the elements that were enabled at the start.
- R8: When several enabled elements share the minimum, the winner index is the lowest of them, and hit is 1.
- R9: A search started with an all-zero mask gives hit 0 and a minimum distance of 4095.
- R10: Opcodes that arrive while busy is high are ignored. No accumulator, counter or weight changes, and no read is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Opcode: 0 none, 1 set counter, 2 load accumulator, 3 read, 4 store weight, 5 accumulate, 6 search |
| pe_mask_i | input | 4 | Element enable mask, bit n for element n |
| db_i | input | 12 | Broadcast data word |
| rd_data_o | output | 12 | OR of enabled accumulators after a read |
| rd_valid_o | output | 1 | Read data valid, one cycle |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| hit_o | output | 1 | At least one element survived the search |
| min_dist_o | output | 12 | Minimum distance found by the last search |
| winner_o | output | 2 | Index of the winning element |

## Verification
A wrong weight word or counter value never appears at the ports by itself. It shows up only in the accumulator read one cycle after the next accumulate and read pair, or in the minimum reported at the end of the following search. For this reason the bench follows every distance run with a read of each element. A fault in the elimination logic shows up 13 cycles after the search starts, as a minimum that is not the smallest accumulator or as a winner that is not the lowest tied index. Ties, a partial mask, an empty mask and operands that differ only in the top bit are driven on purpose to expose such a fault.

// File: rtl/proto_match_pkg.sv
package proto_match_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LDCNT  = 3'd1,
    OP_LDAC   = 3'd2,
    OP_RDAC   = 3'd3,
    OP_LDWC   = 3'd4,
    OP_ADAC   = 3'd5,
    OP_SEARCH = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;
endpackage

// File: rtl/proto_pe.sv
module proto_pe
  import proto_match_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int DEPTH  = 64,
  parameter int ACC_W  = 12,
  parameter int BIT_W  = 4,
  localparam int CNT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  op_e              op_i,
  input  logic [ACC_W-1:0] db_i,
  input  logic             srch_start_i,
  input  logic             srch_step_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             bus_bit_i,
  output logic             drive_o,
  output logic             active_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [WORD_W-1:0] wmem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [ACC_W-1:0]  acc;
  logic              active;
  logic [WORD_W-1:0] cur_w;
  logic [WORD_W-1:0] in_w;

  function automatic logic [WORD_W-1:0] absdiff(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [ACC_W-1:0] widen(input logic [WORD_W-1:0] d);
    return {{(ACC_W-WORD_W){1'b0}}, d};
  endfunction

  assign cur_w = wmem[cnt];
  assign in_w  = db_i[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (sel_i && op_i == OP_LDWC) wmem[cnt] <= in_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (sel_i) begin
      case (op_i)
        OP_LDCNT: cnt <= db_i[CNT_W-1:0];
        OP_LDWC:  cnt <= cnt + CNT_W'(1);
        OP_ADAC: begin
          acc <= acc + widen(absdiff(cur_w, in_w));
          cnt <= cnt + CNT_W'(1);
        end
        OP_LDAC:  acc <= db_i;
        default: ;
      endcase
    end
  end

  assign drive_o = active & ~acc[bit_idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else if (srch_start_i) active <= sel_i;
    else if (srch_step_i && bus_bit_i && !drive_o) active <= 1'b0;
  end

  assign active_o = active;
  assign acc_o    = acc;
endmodule

// File: rtl/proto_search_ctl.sv
module proto_search_ctl #(
  parameter int NUM_PE = 4,
  parameter int ACC_W  = 12,
  parameter int BIT_W  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bus_bit_i,
  input  logic [NUM_PE-1:0] active_i,
  output logic              busy_o,
  output logic              step_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [ACC_W-1:0]  min_dist_o,
  output logic [IDX_W-1:0]  winner_o
);
  logic             busy;
  logic             fin;
  logic [ACC_W-1:0] coll;

  function automatic logic [IDX_W-1:0] lowest(input logic [NUM_PE-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign step_o = busy && !fin;
  assign busy_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      fin        <= 1'b0;
      coll       <= '0;
      bit_idx_o  <= '0;
      done_o     <= 1'b0;
      hit_o      <= 1'b0;
      min_dist_o <= '0;
      winner_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy) begin
        busy      <= 1'b1;
        fin       <= 1'b0;
        coll      <= '0;
        bit_idx_o <= BIT_W'(ACC_W - 1);
      end else if (step_o) begin
        coll <= {coll[ACC_W-2:0], bus_bit_i};
        if (bit_idx_o == '0) fin <= 1'b1;
        else bit_idx_o <= bit_idx_o - BIT_W'(1);
      end else if (busy && fin) begin
        busy       <= 1'b0;
        fin        <= 1'b0;
        done_o     <= 1'b1;
        min_dist_o <= ~coll;
        hit_o      <= |active_i;
        winner_o   <= lowest(active_i);
      end
    end
  end
endmodule

// File: rtl/proto_match_array.sv
module proto_match_array
  import proto_match_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int WORD_W = 6,
  parameter int DEPTH  = 64,
  localparam int ACC_W = WORD_W + $clog2(DEPTH),
  localparam int BIT_W = $clog2(ACC_W),
  localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [NUM_PE-1:0] pe_mask_i,
  input  logic [ACC_W-1:0]  db_i,
  output logic [ACC_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [ACC_W-1:0]  min_dist_o,
  output logic [IDX_W-1:0]  winner_o
);
  op_e                     eff_op;
  logic                    srch_start;
  logic                    srch_step;
  logic [BIT_W-1:0]        bit_idx;
  logic                    bus_bit;
  logic [NUM_PE-1:0]       drive_vec;
  logic [NUM_PE-1:0]       active_vec;
  logic [NUM_PE*ACC_W-1:0] acc_flat;
  logic [ACC_W-1:0]        rd_or;

  assign eff_op     = busy_o ? OP_NOP : op_e'(op_i);
  assign srch_start = (eff_op == OP_SEARCH);
  assign bus_bit    = |drive_vec;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    proto_pe #(
      .WORD_W(WORD_W), .DEPTH(DEPTH), .ACC_W(ACC_W), .BIT_W(BIT_W)
    ) u_pe (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_i        (pe_mask_i[g]),
      .op_i         (eff_op),
      .db_i         (db_i),
      .srch_start_i (srch_start),
      .srch_step_i  (srch_step),
      .bit_idx_i    (bit_idx),
      .bus_bit_i    (bus_bit),
      .drive_o      (drive_vec[g]),
      .active_o     (active_vec[g]),
      .acc_o        (acc_flat[g*ACC_W +: ACC_W])
    );
  end

  always_comb begin
    rd_or = '0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (pe_mask_i[i]) rd_or = rd_or | acc_flat[i*ACC_W +: ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= (eff_op == OP_RDAC);
      if (eff_op == OP_RDAC) rd_data_o <= rd_or;
    end
  end

  proto_search_ctl #(
    .NUM_PE(NUM_PE), .ACC_W(ACC_W), .BIT_W(BIT_W), .IDX_W(IDX_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (srch_start),
    .bus_bit_i  (bus_bit),
    .active_i   (active_vec),
    .busy_o     (busy_o),
    .step_o     (srch_step),
    .bit_idx_o  (bit_idx),
    .done_o     (done_o),
    .hit_o      (hit_o),
    .min_dist_o (min_dist_o),
    .winner_o   (winner_o)
  );
endmodule

// File: rtl/proto_match_array_chk.sv
module proto_match_array_chk
  import proto_match_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int ACC_W  = 12,
  parameter int IDX_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2:0]              op_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    hit_o,
  input logic [ACC_W-1:0]        min_dist_o,
  input logic [IDX_W-1:0]        winner_o,
  input logic                    rd_valid_o,
  input logic [NUM_PE-1:0]       active_vec,
  input logic [NUM_PE*ACC_W-1:0] acc_flat
);
  localparam int LEN_W = $clog2(ACC_W + 2) + 1;
  logic [LEN_W-1:0]  busy_len;
  logic [NUM_PE-1:0] below_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + LEN_W'(1);
    else busy_len <= '0;
  end

  always_comb begin
    below_win = '0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (i < int'(winner_o)) below_win[i] = 1'b1;
    end
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_len == LEN_W'(ACC_W + 1)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_ACTIVE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> (active_vec & ~$past(active_vec)) == '0); // R7
  AST_MIN_IS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && hit_o |-> min_dist_o == acc_flat[winner_o*ACC_W +: ACC_W]); // R7
  AST_LOWEST_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && hit_o |-> active_vec[winner_o] && (active_vec & below_win) == '0); // R8
  AST_EMPTY_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !hit_o |-> &min_dist_o); // R9
  AST_READ_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(op_i) == 3'(OP_RDAC) && !$past(busy_o)); // R5
  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(acc_flat)); // R10
endmodule

bind proto_match_array proto_match_array_chk #(
  .NUM_PE(NUM_PE), .ACC_W(ACC_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_i       (op_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .hit_o      (hit_o),
  .min_dist_o (min_dist_o),
  .winner_o   (winner_o),
  .rd_valid_o (rd_valid_o),
  .active_vec (active_vec),
  .acc_flat   (acc_flat)
);

// File: tb/proto_match_array_test.sv
module proto_match_array_test;
  localparam int NPE = 4;
  localparam int AW  = 12;
  localparam int ND  = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_i = 3'd0;
  logic [NPE-1:0] pe_mask_i = '0;
  logic [AW-1:0] db_i = '0;
  logic [AW-1:0] rd_data_o;
  logic          rd_valid_o, busy_o, done_o, hit_o;
  logic [AW-1:0] min_dist_o;
  logic [1:0]    winner_o;

  int n_chk = 0;
  int n_fail = 0;
  int mw [NPE][ND];
  int macc [NPE];
  int mcnt [NPE];
  int xv [ND];

  always #2.5 clk = ~clk;

  proto_match_array uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .pe_mask_i(pe_mask_i), .db_i(db_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
    .done_o(done_o), .hit_o(hit_o), .min_dist_o(min_dist_o), .winner_o(winner_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int adiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // Drive at a negedge, captured at the next posedge, return at the following negedge.
  task automatic do_op(input int o, input int m, input int d, input bit model);
    op_i = 3'(o); pe_mask_i = NPE'(m); db_i = AW'(d);
    @(negedge clk);
    op_i = 3'd0;
    if (model) begin
      for (int p = 0; p < NPE; p++) begin
        if (m[p]) begin
          case (o)
            1: mcnt[p] = d & 63;
            2: macc[p] = d & 12'hFFF;
            4: begin mw[p][mcnt[p]] = d & 63; mcnt[p] = (mcnt[p] + 1) & 63; end
            5: begin
              macc[p] = (macc[p] + adiff(mw[p][mcnt[p]], d & 63)) & 12'hFFF;
              mcnt[p] = (mcnt[p] + 1) & 63;
            end
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic read_pe(input int p, input string req);
    do_op(3, 1 << p, 0, 1'b1);
    chk({req, " rd_valid"}, int'(rd_valid_o), 1);
    chk({req, " acc"}, int'(rd_data_o), macc[p]);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 60) begin @(negedge clk); n++; end
  endtask

  task automatic search_check(input int m, input string req);
    int n, best, win;
    do_op(6, m, 0, 1'b1);
    wait_done(n);
    best = 4095; win = -1;
    for (int p = 0; p < NPE; p++) begin
      if (m[p] && (win < 0 || macc[p] < best)) begin best = macc[p]; win = p; end
    end
    chk({req, " R7 latency"}, n, AW + 1);
    chk({req, " R7 min"}, int'(min_dist_o), best);
    chk({req, " R8 hit"}, int'(hit_o), (win >= 0) ? 1 : 0);
    if (win >= 0) chk({req, " R8 winner"}, int'(winner_o), win);
  endtask

  task automatic run_vector(input int ndim, input string req);
    do_op(2, 15, 0, 1'b1);
    do_op(1, 15, 0, 1'b1);
    for (int d = 0; d < ndim; d++) do_op(5, 15, xv[d], 1'b1);
    for (int p = 0; p < NPE; p++) read_pe(p, {req, " R4"});
    search_check(15, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd4321));
    for (int p = 0; p < NPE; p++) begin macc[p] = 0; mcnt[p] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 rd_valid", int'(rd_valid_o), 0);
    chk("R1 rd_data", int'(rd_data_o), 0);
    chk("R1 min", int'(min_dist_o), 0);
    chk("R1 hit", int'(hit_o), 0);
    chk("R1 winner", int'(winner_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_pe(2, "R1 acc");

    // R2: load random weights into each element separately
    for (int p = 0; p < NPE; p++) begin
      do_op(1, 1 << p, 0, 1'b1);
      for (int d = 0; d < ND; d++) do_op(4, 1 << p, int'($urandom_range(63)), 1'b1);
    end
    // R2 counter wrap: after 64 stores the counter is back at 0; accumulate vs 0
    do_op(2, 1, 0, 1'b1);
    do_op(5, 1, 0, 1'b1);
    read_pe(0, "R2 wrap");

    // R3: set counter to 40, accumulate against 0 returns the weight there
    do_op(2, 15, 0, 1'b1);
    do_op(1, 15, 40, 1'b1);
    do_op(5, 15, 0, 1'b1);
    for (int p = 0; p < NPE; p++) begin
      read_pe(p, "R3");
      chk("R3 weight", macc[p], mw[p][40]);
    end

    // R4/R7/R8: random full-length vectors
    for (int v = 0; v < 12; v++) begin
      for (int d = 0; d < ND; d++) xv[d] = int'($urandom_range(63));
      run_vector(ND, "rand");
    end
    // short vectors with random extremes
    for (int v = 0; v < 4; v++) begin
      for (int d = 0; d < ND; d++) xv[d] = ($urandom_range(1) == 1) ? 63 : 0;
      run_vector(8 + v * 4, "short");
    end

    // R8: elements 1 and 2 get identical weights equal to the input, tie at 0
    for (int d = 0; d < ND; d++) xv[d] = int'($urandom_range(63));
    do_op(1, 6, 0, 1'b1);
    for (int d = 0; d < ND; d++) do_op(4, 6, xv[d], 1'b1);
    run_vector(ND, "R8 tie");
    chk("R8 tie winner", int'(winner_o), 1);
    chk("R8 tie min", int'(min_dist_o), 0);

    // R5: wired-OR read and load accumulator
    do_op(2, 1, 12'h0F0, 1'b1);
    do_op(2, 2, 12'h00F, 1'b1);
    do_op(3, 3, 0, 1'b1);
    chk("R5 or read", int'(rd_data_o), 12'h0FF);
    @(negedge clk);
    chk("R5 valid drop", int'(rd_valid_o), 0);

    // R6: masked-off element 1 untouched, opcode 0 changes nothing
    do_op(2, 15, 100, 1'b1);
    do_op(2, 5, 7, 1'b1);
    do_op(0, 15, 999, 1'b1);
    do_op(7, 15, 999, 1'b1);
    read_pe(1, "R6 masked");
    read_pe(0, "R6 enabled");
    chk("R6 value", macc[1], 100);

    // R7/R8: top-bit difference, partial masks, equal loaded values
    do_op(2, 1, 12'h800, 1'b1);
    do_op(2, 2, 12'h7FF, 1'b1);
    do_op(2, 4, 12'h7FF, 1'b1);
    do_op(2, 8, 12'hFFF, 1'b1);
    search_check(15, "msb");
    search_check(9, "partial");
    search_check(12, "partial2");
    search_check(8, "single");

    // R9: empty mask
    do_op(6, 0, 0, 1'b1);
    wait_done(n);
    chk("R9 hit", int'(hit_o), 0);
    chk("R9 min", int'(min_dist_o), 4095);

    // R10: opcodes during a search are ignored
    do_op(2, 15, 5, 1'b1);
    do_op(6, 15, 0, 1'b1);
    do_op(2, 15, 12'hABC, 1'b0);
    do_op(3, 15, 0, 1'b0);
    chk("R10 no read", int'(rd_valid_o), 0);
    do_op(1, 15, 9, 1'b0);
    wait_done(n);
    chk("R10 min", int'(min_dist_o), 5);
    for (int p = 0; p < NPE; p++) read_pe(p, "R10");

    finish_run();
  end
endmodule